// File: doc/BRIEF.md
# Compact 16-bit Instruction Format Decoder

This block is a purely combinational front-end decoder for a 16-bit compressed RISC instruction set. It takes one instruction halfword and sorts it into one of nineteen instruction formats. The format is given twice: as a one-hot vector and as an encoded index. The block also pulls out the fields that format carries: sub-operation code, register numbers, raw immediate, branch condition, register list and the link/extra-register flag. Any halfword that no format accepts is reported as undefined, and all of its field outputs are then zero.

The format is chosen from instruction bits 15..6 alone. A table of mask/value patterns is compared against those ten bits, one matcher per format. Three formats carry carve-outs, so that overlapping or reserved sub-encodings go to the right format or to undefined. The decoder holds no state and produces one output set per input word. Register file access, execution and exception entry belong to the stages that consume these outputs.

Top module: `dec16_format_decoder`

## Requirements
- R1: For every input word exactly one of the 19 `fmt_onehot` bits or `undef` is high. `fmt_id` equals the index of the high one-hot bit, or 19 when `undef` is high.
- R2: Bits 5..0 of `instr` never change `fmt_id`, `fmt_onehot` or `undef`.
- R3: Format indices and bit patterns (bits 15 downward, x = don't care) are:
  - 0 = 000 shift-immediate.
  - 1 = 00011 add/sub.
  - 2 = 001 imm8 ALU.
  - 3 = 010000 register ALU.
  - 4 = 010001 high-register/branch-exchange.
  - 5 = 01001 PC-relative load.
  - 6 = 0101xx0 register-offset transfer.
  - 7 = 0101xx1 sign-extending transfer.
  - 8 = 011 immediate-offset transfer.
  - 9 = 1000 halfword transfer.
  - 10 = 1001 SP-relative transfer.
  - 11 = 1010 address generation.
  - 12 = 10110000 SP adjust.
  - 13 = 1011x10x push/pop.
  - 14 = 1100 multiple transfer.
  - 15 = 1101 conditional branch.
  - 16 = 11011111 software interrupt.
  - 17 = 11100 branch.
  - 18 = 1111 long branch-with-link half.
- R4: A shift-immediate word whose bits 12..11 are 11 is not a shift. It decodes as format 1.
- R5: In format 4, sub-op (bits 9..8) 0, 1 or 2 with both bit 7 and bit 6 clear is undefined. Sub-op 3 with bit 7 set is also undefined.
- R6: In the conditional-branch space, condition (bits 11..8) 1110 is undefined and condition 1111 decodes as format 16.
- R7: Words matching no pattern (for example 11101xxxxx, or 1011 words outside formats 12 and 13) are undefined. For these, `subop`, `rd`, `rs`, `ro`, `imm`, `cond`, `rlist` and `link` are all zero.
- R8: In format 4, `rd` is {bit7, bits2..0} and `rs` is {bit6, bits5..3}.
- R9: `subop` is the format's own operation field:
  - bits 12..11 for formats 0, 2 and 8.
  - bits 10..9 for format 1.
  - bits 9..6 for format 3.
  - bits 9..8 for format 4.
  - bits 11..10 for formats 6 and 7.
  - bit 11 for formats 9, 10, 11, 13, 14 and 18.
  - bit 7 for format 12.
  - zero otherwise.
- R10: `rd` is bits 2..0 for formats 0, 1, 3, 6, 7, 8 and 9, and bits 10..8 for formats 2, 5, 10, 11 and 14. `rs` is bits 5..3 for formats 0, 1, 3, 6, 7, 8 and 9. `ro` is bits 8..6 for formats 1, 6 and 7. Each of these is zero where none of the above applies.
- R11: `imm` is zero-extended and comes from:
  - bits 10..6 for formats 0, 8 and 9.
  - bits 8..6 for format 1.
  - bits 7..0 for formats 2, 5, 10, 11, 15 and 16.
  - bits 6..0 for format 12.
  - bits 10..0 for formats 17 and 18.
  - zero otherwise.
- R12: `cond` is bits 11..8 in format 15. `rlist` is bits 7..0 in formats 13 and 14. `link` is bit 8 in format 13. All three are zero otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 16 | Instruction halfword to decode |
| fmt_onehot | output | 19 | One bit per accepted format |
| fmt_id | output | 5 | Encoded format index, 19 = undefined |
| undef | output | 1 | No format accepts the word |
| subop | output | 4 | Format-specific operation code |
| rd | output | 4 | Destination/base register number |
| rs | output | 4 | Source/base register number |
| ro | output | 3 | Offset register or 3-bit operand |
| imm | output | 11 | Raw zero-extended immediate |
| cond | output | 4 | Branch condition code |
| rlist | output | 8 | Register list |
| link | output | 1 | Extra link/PC register flag |

## Verification
Two pairs of patterns can match the same word at once. Shift-immediate and add/sub both match 00011, and conditional branch and software interrupt both match 11011111. The resolution of each pair is the central hazard. An exhaustive sweep of all 1024 values of bits 15..6 drives both overlaps, with random low bits. Each result is judged against an independently written priority reference: the exact winning format, a single active class, and the correct extracted fields. Directed words then hit the reserved high-register and condition-1110 carve-outs, and the low-bit-invariance pairs.

// File: rtl/dec16_pkg.sv
package dec16_pkg;

    localparam int INSTR_W = 16;
    localparam int SEL_LSB = 6;
    localparam int SEL_W   = INSTR_W - SEL_LSB;
    localparam int NUM_FMT = 19;
    localparam int ID_W    = $clog2(NUM_FMT + 1);

    typedef enum logic [ID_W-1:0] {
        FMT_SHIFT   = 5'd0,
        FMT_ADDSUB  = 5'd1,
        FMT_IMM8    = 5'd2,
        FMT_ALU     = 5'd3,
        FMT_HIREG   = 5'd4,
        FMT_PCLOAD  = 5'd5,
        FMT_REGOFS  = 5'd6,
        FMT_SIGNEXT = 5'd7,
        FMT_IMMOFS  = 5'd8,
        FMT_HALF    = 5'd9,
        FMT_SPREL   = 5'd10,
        FMT_ADDR    = 5'd11,
        FMT_SPADJ   = 5'd12,
        FMT_PUSHPOP = 5'd13,
        FMT_MULTI   = 5'd14,
        FMT_BCOND   = 5'd15,
        FMT_SWI     = 5'd16,
        FMT_BRANCH  = 5'd17,
        FMT_BL      = 5'd18,
        FMT_UNDEF   = 5'd19
    } fmt_e;

    typedef struct packed {
        logic [3:0]  subop;
        logic [3:0]  rd;
        logic [3:0]  rs;
        logic [2:0]  ro;
        logic [10:0] imm;
        logic [3:0]  cond;
        logic [7:0]  rlist;
        logic        link;
    } fields_t;

    // Care mask over instruction bits 15..6 for each format.
    function automatic logic [SEL_W-1:0] pat_mask(input int idx);
        case (idx)
            0, 2, 8:            pat_mask = 10'b1110000000;
            1, 5, 17:           pat_mask = 10'b1111100000;
            3, 4:               pat_mask = 10'b1111110000;
            6, 7:               pat_mask = 10'b1111001000;
            12, 16:             pat_mask = 10'b1111111100;
            13:                 pat_mask = 10'b1111011000;
            default:            pat_mask = 10'b1111000000;
        endcase
    endfunction

    // Required value of the cared-for bits for each format.
    function automatic logic [SEL_W-1:0] pat_value(input int idx);
        case (idx)
            0:       pat_value = 10'b0000000000;
            1:       pat_value = 10'b0001100000;
            2:       pat_value = 10'b0010000000;
            3:       pat_value = 10'b0100000000;
            4:       pat_value = 10'b0100010000;
            5:       pat_value = 10'b0100100000;
            6:       pat_value = 10'b0101000000;
            7:       pat_value = 10'b0101001000;
            8:       pat_value = 10'b0110000000;
            9:       pat_value = 10'b1000000000;
            10:      pat_value = 10'b1001000000;
            11:      pat_value = 10'b1010000000;
            12:      pat_value = 10'b1011000000;
            13:      pat_value = 10'b1011010000;
            14:      pat_value = 10'b1100000000;
            15:      pat_value = 10'b1101000000;
            16:      pat_value = 10'b1101111100;
            17:      pat_value = 10'b1110000000;
            default: pat_value = 10'b1111000000;
        endcase
    endfunction

    // Carve-outs: sub-encodings a pattern matches but must not claim.
    // sel[i] is instruction bit i+6.
    function automatic logic pat_excluded(input int idx, input logic [SEL_W-1:0] sel);
        case (idx)
            0:  pat_excluded = (sel[6:5] == 2'b11);
            4:  pat_excluded = ((sel[3:2] != 2'b11) && !sel[1] && !sel[0]) ||
                               ((sel[3:2] == 2'b11) && sel[1]);
            15: pat_excluded = (sel[5:3] == 3'b111);
            default: pat_excluded = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/dec16_pattern_match.sv
module dec16_pattern_match
    import dec16_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic [SEL_W-1:0] sel,
    output logic             hit
);
    localparam logic [SEL_W-1:0] MASK  = pat_mask(IDX);
    localparam logic [SEL_W-1:0] VALUE = pat_value(IDX);

    always_comb begin
        hit = ((sel & MASK) == VALUE) && !pat_excluded(IDX, sel);
    end
endmodule

// File: rtl/dec16_resolve.sv
module dec16_resolve
    import dec16_pkg::*;
(
    input  logic [NUM_FMT-1:0] hits,
    output logic [NUM_FMT-1:0] onehot,
    output fmt_e               fmt,
    output logic               none
);
    always_comb begin
        onehot = '0;
        fmt    = FMT_UNDEF;
        // Patterns are disjoint after carve-outs; lowest index wins defensively.
        for (int i = NUM_FMT - 1; i >= 0; i--) begin
            if (hits[i]) begin
                fmt = fmt_e'(i[ID_W-1:0]);
            end
        end
        if (fmt != FMT_UNDEF) begin
            onehot[fmt] = 1'b1;
        end
        none = (fmt == FMT_UNDEF);
    end
endmodule

// File: rtl/dec16_fields.sv
module dec16_fields
    import dec16_pkg::*;
(
    input  logic [12:0] w,
    input  fmt_e        fmt,
    output fields_t     f
);
    always_comb begin
        f = '0;
        unique case (fmt)
            FMT_SHIFT: begin
                f.subop = {2'b00, w[12:11]};
                f.rd    = {1'b0, w[2:0]};
                f.rs    = {1'b0, w[5:3]};
                f.imm   = {6'd0, w[10:6]};
            end
            FMT_ADDSUB: begin
                f.subop = {2'b00, w[10:9]};
                f.rd    = {1'b0, w[2:0]};
                f.rs    = {1'b0, w[5:3]};
                f.ro    = w[8:6];
                f.imm   = {8'd0, w[8:6]};
            end
            FMT_IMM8: begin
                f.subop = {2'b00, w[12:11]};
                f.rd    = {1'b0, w[10:8]};
                f.imm   = {3'd0, w[7:0]};
            end
            FMT_ALU: begin
                f.subop = w[9:6];
                f.rd    = {1'b0, w[2:0]};
                f.rs    = {1'b0, w[5:3]};
            end
            FMT_HIREG: begin
                f.subop = {2'b00, w[9:8]};
                f.rd    = {w[7], w[2:0]};
                f.rs    = {w[6], w[5:3]};
            end
            FMT_PCLOAD: begin
                f.rd    = {1'b0, w[10:8]};
                f.imm   = {3'd0, w[7:0]};
            end
            FMT_REGOFS, FMT_SIGNEXT: begin
                f.subop = {2'b00, w[11:10]};
                f.rd    = {1'b0, w[2:0]};
                f.rs    = {1'b0, w[5:3]};
                f.ro    = w[8:6];
            end
            FMT_IMMOFS: begin
                f.subop = {2'b00, w[12:11]};
                f.rd    = {1'b0, w[2:0]};
                f.rs    = {1'b0, w[5:3]};
                f.imm   = {6'd0, w[10:6]};
            end
            FMT_HALF: begin
                f.subop = {3'b000, w[11]};
                f.rd    = {1'b0, w[2:0]};
                f.rs    = {1'b0, w[5:3]};
                f.imm   = {6'd0, w[10:6]};
            end
            FMT_SPREL, FMT_ADDR: begin
                f.subop = {3'b000, w[11]};
                f.rd    = {1'b0, w[10:8]};
                f.imm   = {3'd0, w[7:0]};
            end
            FMT_SPADJ: begin
                f.subop = {3'b000, w[7]};
                f.imm   = {4'd0, w[6:0]};
            end
            FMT_PUSHPOP: begin
                f.subop = {3'b000, w[11]};
                f.rlist = w[7:0];
                f.link  = w[8];
            end
            FMT_MULTI: begin
                f.subop = {3'b000, w[11]};
                f.rd    = {1'b0, w[10:8]};
                f.rlist = w[7:0];
            end
            FMT_BCOND: begin
                f.cond  = w[11:8];
                f.imm   = {3'd0, w[7:0]};
            end
            FMT_SWI: begin
                f.imm   = {3'd0, w[7:0]};
            end
            FMT_BRANCH: begin
                f.imm   = w[10:0];
            end
            FMT_BL: begin
                f.subop = {3'b000, w[11]};
                f.imm   = w[10:0];
            end
            FMT_UNDEF: begin
                f = '0;
            end
            default: begin
                f = '0;
            end
        endcase
    end
endmodule

// File: rtl/dec16_format_decoder.sv
module dec16_format_decoder
    import dec16_pkg::*;
(
    input  logic [15:0] instr,
    output logic [18:0] fmt_onehot,
    output logic [4:0]  fmt_id,
    output logic        undef,
    output logic [3:0]  subop,
    output logic [3:0]  rd,
    output logic [3:0]  rs,
    output logic [2:0]  ro,
    output logic [10:0] imm,
    output logic [3:0]  cond,
    output logic [7:0]  rlist,
    output logic        link
);
    logic [SEL_W-1:0]   sel;
    logic [NUM_FMT-1:0] hits;
    fmt_e               fmt;
    fields_t            fld;

    assign sel = instr[INSTR_W-1:SEL_LSB];

    for (genvar g = 0; g < NUM_FMT; g++) begin : g_match
        dec16_pattern_match #(.IDX(g)) u_match (
            .sel (sel),
            .hit (hits[g])
        );
    end

    dec16_resolve u_resolve (
        .hits   (hits),
        .onehot (fmt_onehot),
        .fmt    (fmt),
        .none   (undef)
    );

    dec16_fields u_fields (
        .w   (instr[12:0]),
        .fmt (fmt),
        .f   (fld)
    );

    assign fmt_id = fmt;
    assign subop  = fld.subop;
    assign rd     = fld.rd;
    assign rs     = fld.rs;
    assign ro     = fld.ro;
    assign imm    = fld.imm;
    assign cond   = fld.cond;
    assign rlist  = fld.rlist;
    assign link   = fld.link;
endmodule

// File: rtl/dec16_checker.sv
module dec16_checker (
    input logic [15:0] instr,
    input logic [18:0] fmt_onehot,
    input logic [4:0]  fmt_id,
    input logic        undef,
    input logic [3:0]  subop,
    input logic [3:0]  rd,
    input logic [3:0]  rs,
    input logic [2:0]  ro,
    input logic [10:0] imm,
    input logic [3:0]  cond,
    input logic [7:0]  rlist,
    input logic        link
);
    always_comb begin
        assert_single_class_R1: assert ($countones({fmt_onehot, undef}) == 1)
            else $error("R1: class count not one");
        assert_id_agrees_R1: assert (undef ? (fmt_id == 5'd19) : fmt_onehot[fmt_id])
            else $error("R1: encoded id disagrees with one-hot");
        assert_shift_handoff_R4: assert (instr[15:11] != 5'b00011 || fmt_id == 5'd1)
            else $error("R4: 00011 not add/sub");
        assert_swi_claim_R6: assert (instr[15:8] != 8'hDF || fmt_id == 5'd16)
            else $error("R6: 11011111 not software interrupt");
        assert_cond_reserved_R6: assert (instr[15:8] != 8'hDE || undef)
            else $error("R6: condition 1110 not undefined");
        assert_undef_quiet_R7: assert (!undef ||
            ({subop, rd, rs, ro, imm, cond, rlist, link} == '0))
            else $error("R7: fields not zero on undefined");
        assert_hireg_extend_R8: assert (fmt_id != 5'd4 ||
            (rd == {instr[7], instr[2:0]} && rs == {instr[6], instr[5:3]}))
            else $error("R8: high register numbers wrong");
        assert_addsub_operand_R10: assert (fmt_id != 5'd1 || ro == instr[8:6])
            else $error("R10: add/sub third operand wrong");
    end
endmodule

bind dec16_format_decoder dec16_checker u_chk (.*);

// File: tb/tb_dec16_format_decoder.sv
module tb_dec16_format_decoder;
    logic        clk = 1'b0;
    logic [15:0] instr = 16'h0000;
    logic [18:0] fmt_onehot;
    logic [4:0]  fmt_id;
    logic        undef;
    logic [3:0]  subop, rd, rs, cond;
    logic [2:0]  ro;
    logic [10:0] imm;
    logic [7:0]  rlist;
    logic        link;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    dec16_format_decoder dut (
        .instr(instr), .fmt_onehot(fmt_onehot), .fmt_id(fmt_id), .undef(undef),
        .subop(subop), .rd(rd), .rs(rs), .ro(ro), .imm(imm), .cond(cond),
        .rlist(rlist), .link(link)
    );

    // Reference classification written from the pattern list, priority order.
    function automatic int ref_id(input logic [15:0] w);
        casez (w[15:6])
            10'b00011?????: return 1;
            10'b000???????: return 0;
            10'b001???????: return 2;
            10'b010000????: return 3;
            10'b010001????: begin
                if (w[9:8] != 2'b11 && !w[7] && !w[6]) return 19;
                if (w[9:8] == 2'b11 && w[7]) return 19;
                return 4;
            end
            10'b01001?????: return 5;
            10'b0101??0???: return 6;
            10'b0101??1???: return 7;
            10'b011???????: return 8;
            10'b1000??????: return 9;
            10'b1001??????: return 10;
            10'b1010??????: return 11;
            10'b10110000??: return 12;
            10'b1011?10???: return 13;
            10'b1100??????: return 14;
            10'b1101??????: begin
                if (w[11:8] == 4'hF) return 16;
                if (w[11:8] == 4'hE) return 19;
                return 15;
            end
            10'b11100?????: return 17;
            10'b1111??????: return 18;
            default: return 19;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s word=%h actual=%0h expected=%0h", req, instr, act, exp);
        end
    endtask

    task automatic apply_and_check(input logic [15:0] w);
        int id;
        logic [3:0]  e_sub, e_rd, e_rs, e_cond;
        logic [2:0]  e_ro;
        logic [10:0] e_imm;
        logic [7:0]  e_rl;
        logic        e_lk;
        @(posedge clk);
        instr = w;
        @(negedge clk);
        id = ref_id(w);
        e_sub = '0; e_rd = '0; e_rs = '0; e_cond = '0; e_ro = '0;
        e_imm = '0; e_rl = '0; e_lk = 1'b0;
        // R9 subop
        case (id)
            0, 2, 8: e_sub = {2'b0, w[12:11]};
            1:       e_sub = {2'b0, w[10:9]};
            3:       e_sub = w[9:6];
            4:       e_sub = {2'b0, w[9:8]};
            6, 7:    e_sub = {2'b0, w[11:10]};
            9, 10, 11, 13, 14, 18: e_sub = {3'b0, w[11]};
            12:      e_sub = {3'b0, w[7]};
            default: e_sub = '0;
        endcase
        // R10 / R8 registers
        case (id)
            0, 1, 3, 6, 7, 8, 9: begin e_rd = {1'b0, w[2:0]}; e_rs = {1'b0, w[5:3]}; end
            2, 5, 10, 11, 14:    e_rd = {1'b0, w[10:8]};
            4: begin e_rd = {w[7], w[2:0]}; e_rs = {w[6], w[5:3]}; end
            default: ;
        endcase
        if (id == 1 || id == 6 || id == 7) e_ro = w[8:6];
        // R11 immediate
        case (id)
            0, 8, 9:  e_imm = {6'd0, w[10:6]};
            1:        e_imm = {8'd0, w[8:6]};
            2, 5, 10, 11, 15, 16: e_imm = {3'd0, w[7:0]};
            12:       e_imm = {4'd0, w[6:0]};
            17, 18:   e_imm = w[10:0];
            default:  e_imm = '0;
        endcase
        // R12 condition, list, link
        if (id == 15) e_cond = w[11:8];
        if (id == 13 || id == 14) e_rl = w[7:0];
        if (id == 13) e_lk = w[8];

        check("R3 fmt_id", {27'd0, fmt_id}, id);
        check("R1 onehot", {13'd0, fmt_onehot}, (id == 19) ? 32'd0 : (32'd1 << id));
        check("R7 undef", {31'd0, undef}, {31'd0, (id == 19)});
        check("R9 subop", {28'd0, subop}, {28'd0, e_sub});
        check((id == 4) ? "R8 rd" : "R10 rd", {28'd0, rd}, {28'd0, e_rd});
        check((id == 4) ? "R8 rs" : "R10 rs", {28'd0, rs}, {28'd0, e_rs});
        check("R10 ro", {29'd0, ro}, {29'd0, e_ro});
        check("R11 imm", {21'd0, imm}, {21'd0, e_imm});
        check("R12 cond", {28'd0, cond}, {28'd0, e_cond});
        check("R12 rlist", {24'd0, rlist}, {24'd0, e_rl});
        check("R12 link", {31'd0, link}, {31'd0, e_lk});
    endtask

    // R2: same top ten bits, different low six bits, same classification.
    task automatic low_bits_check(input logic [9:0] top, input logic [5:0] a, input logic [5:0] b);
        logic [4:0] id_a;
        logic [18:0] oh_a;
        @(posedge clk);
        instr = {top, a};
        @(negedge clk);
        id_a = fmt_id;
        oh_a = fmt_onehot;
        @(posedge clk);
        instr = {top, b};
        @(negedge clk);
        check("R2 id invariant", {27'd0, fmt_id}, {27'd0, id_a});
        check("R2 onehot invariant", {13'd0, fmt_onehot}, {13'd0, oh_a});
    endtask

    initial begin
        int seed_val;
        seed_val = $urandom(32'd20240611);
        // Initial word 0: shift-immediate, format 0 (R3).
        @(negedge clk);
        check("R3 initial word", {27'd0, fmt_id}, 32'd0);

        // Directed corners.
        apply_and_check(16'h1800);   // R4: 00011 -> add/sub
        apply_and_check(16'h1FFF);   // R4
        apply_and_check(16'h4400);   // R5: hi ADD, no high flags
        apply_and_check(16'h4600);   // R5: hi MOV, no high flags
        apply_and_check(16'h4780);   // R5: branch-exchange with high destination
        apply_and_check(16'h4778);   // R5/R8: legal branch-exchange from high source
        apply_and_check(16'h44C7);   // R8: both high flags
        apply_and_check(16'hDE12);   // R6: condition 1110
        apply_and_check(16'hDF34);   // R6: software interrupt
        apply_and_check(16'hD0FF);   // R12 conditional branch
        apply_and_check(16'hE800);   // R7: 11101 unlisted
        apply_and_check(16'hB200);   // R7: 1011 gap
        apply_and_check(16'hB5FF);   // R12 push with link
        apply_and_check(16'hB080);   // R11 SP adjust, subtract flag
        apply_and_check(16'hC7AA);   // R12 multiple transfer

        // Exhaustive sweep of selecting bits with random low bits (R1, R3).
        for (int t = 0; t < 1024; t++) begin
            apply_and_check({t[9:0], 6'($urandom())});
        end

        // R2 invariance across every selecting value.
        for (int t = 0; t < 1024; t++) begin
            low_bits_check(t[9:0], 6'h00, 6'($urandom()) | 6'h01);
        end

        // Random full words.
        for (int k = 0; k < 2000; k++) begin
            apply_and_check(16'($urandom()));
        end

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule